// File: doc/BRIEF.md
# Typed Interrupt Pending Register

This block holds a 32-bit register of pending interrupt requests in which every bit has a fixed type: level, edge, software or non-maskable. Hardware request lines pass through a two-stage synchroniser. Level-type bits copy their synchronised line, and edge-type and non-maskable bits latch a rising edge. Software can post requests through a set command and withdraw them through a clear command. Both commands carry a 32-bit data word, and the bit type decides which bits each command can reach.

An enable register gates the pending bits onto a pending-and-enabled output. Non-maskable bits pass this gate even when their enable bit is zero. Each bit also has a fixed priority level. A wait-for-interrupt command loads the current interrupt level and halts the core. The core is not halted if a pending-and-enabled bit already sits above the new level. A halted core is released when such a bit appears. Choosing among requests and dispatching a vector are done outside this block.

Top module: `irq_pend_unit`

## Requirements
- R1: After a synchronous reset, pending, enable, pending-and-enabled, interrupt level and halt are all zero.
- R2: A set command ORs its data into the pending register, but only into software-type bits (default bits 30..16). Level-, edge- and non-maskable-type bits are left unchanged.
- R3: A clear command clears the data bits that are software-type or edge-type (default edge bits 15..8). Level-type bits (default 7..0) and the non-maskable bit (default bit 31) are unaffected.
- R4: An edge-type or non-maskable bit is set by a rising edge of its line. It is first visible 3 clock edges after the line is sampled high, and it stays set after the line falls.
- R5: A level-type bit follows its line with a latency of 3 clock edges, in both directions.
- R6: If a hardware rising edge and a clear of the same bit fall on the same edge, the bit ends set. If a set and a clear of the same software bit fall on the same edge, the bit also ends set.
- R7: A non-maskable-taken pulse clears all non-maskable-type pending bits.
- R8: The pending-and-enabled output equals pending AND enable, with non-maskable bits passed regardless of enable. It updates on the same edge as pending.
- R9: A wait command loads its level into the interrupt level on the next edge. On that edge the halt flag is set if, and only if, no pending-and-enabled bit has a priority level above the new level. Bit i has level (i mod 4)+1 by default, and a non-maskable bit counts as above any level.
- R10: While halted, the halt flag clears on the edge after a pending-and-enabled bit above the current level appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Asynchronous hardware request lines |
| sw_set_en | input | 1 | Software set command strobe |
| sw_set_data | input | 32 | Bits to set |
| sw_clr_en | input | 1 | Software clear command strobe |
| sw_clr_data | input | 32 | Bits to clear |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | 32 | New enable value |
| nmi_taken | input | 1 | Non-maskable request accepted; clears its bits |
| wait_req | input | 1 | Wait-for-interrupt command |
| wait_level | input | 4 | Level loaded by the wait command |
| pending | output | 32 | Pending register |
| enabled_pending | output | 32 | Pending bits that are enabled, plus non-maskable bits |
| int_level | output | 4 | Current interrupt level |
| halted | output | 1 | Core halt flag |

## Verification
Two collisions matter in this block. A synchronised rising edge and a software clear can hit the same edge-type bit on one clock. The bench provokes this by starting a line high and issuing the clear exactly two clocks later, so that both act on the edge where the bit latches; the bit must end set. A set and a clear aimed at one software bit in the same cycle are also issued together, and the bench judges them the same way. For the wait command, the bench checks a bit that is already pending above the new level as well as a bit arriving while halted. It also checks that a disabled request leaves the core halted.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned IRQ_BITS = 32;
  localparam int unsigned IRQ_LVL_W = 4;
  localparam logic [IRQ_BITS-1:0] DEF_LEVEL_MASK = 32'h0000_00FF;
  localparam logic [IRQ_BITS-1:0] DEF_EDGE_MASK  = 32'h0000_FF00;
  localparam logic [IRQ_BITS-1:0] DEF_SW_MASK    = 32'h7FFF_0000;
  localparam logic [IRQ_BITS-1:0] DEF_NMI_MASK   = 32'h8000_0000;
  // bit i priority = (i mod 4) + 1
  localparam logic [IRQ_BITS*IRQ_LVL_W-1:0] DEF_BIT_LVL =
    128'h4321_4321_4321_4321_4321_4321_4321_4321;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned NBITS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] lines,
  output logic [NBITS-1:0] synced,
  output logic [NBITS-1:0] rise
);
  logic [NBITS-1:0] chain [STAGES];
  logic [NBITS-1:0] last_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= lines;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= chain[STAGES-1];
  end

  assign synced = chain[STAGES-1];
  assign rise   = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_above_mask.sv
module irq_above_mask #(
  parameter int unsigned NBITS = 32,
  parameter int unsigned LVL_W = 4,
  parameter logic [NBITS*LVL_W-1:0] BIT_LVL = '0,
  parameter logic [NBITS-1:0] NMI_MASK = '0
) (
  input  logic [LVL_W-1:0] thr,
  output logic [NBITS-1:0] above
);
  genvar i;
  generate
    for (i = 0; i < NBITS; i++) begin : g_bit
      if (NMI_MASK[i]) begin : g_nmi
        assign above[i] = 1'b1;
      end else begin : g_cmp
        assign above[i] = (BIT_LVL[i*LVL_W +: LVL_W] > thr);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int unsigned NBITS = 32,
  parameter logic [NBITS-1:0] LEVEL_MASK = '0,
  parameter logic [NBITS-1:0] EDGE_MASK  = '0,
  parameter logic [NBITS-1:0] SW_MASK    = '0,
  parameter logic [NBITS-1:0] NMI_MASK   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] synced,
  input  logic [NBITS-1:0] rise,
  input  logic             set_en,
  input  logic [NBITS-1:0] set_data,
  input  logic             clr_en,
  input  logic [NBITS-1:0] clr_data,
  input  logic             nmi_taken,
  output logic [NBITS-1:0] pend_nxt,
  output logic [NBITS-1:0] pend_q
);
  localparam logic [NBITS-1:0] CLEARABLE = SW_MASK | EDGE_MASK;
  localparam logic [NBITS-1:0] HW_EDGE   = EDGE_MASK | NMI_MASK;

  logic [NBITS-1:0] set_m, clr_m;

  always_comb begin
    set_m = set_en ? (set_data & SW_MASK) : '0;
    clr_m = clr_en ? (clr_data & CLEARABLE) : '0;
    clr_m = clr_m & ~set_m;
    pend_nxt = (pend_q | set_m) & ~clr_m;
    if (nmi_taken) pend_nxt = pend_nxt & ~NMI_MASK;
    pend_nxt = pend_nxt | (rise & HW_EDGE);
    pend_nxt = (pend_nxt & ~LEVEL_MASK) | (synced & LEVEL_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int unsigned NBITS = irq_pend_pkg::IRQ_BITS,
  parameter int unsigned LVL_W = irq_pend_pkg::IRQ_LVL_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NBITS-1:0] LEVEL_MASK = irq_pend_pkg::DEF_LEVEL_MASK,
  parameter logic [NBITS-1:0] EDGE_MASK  = irq_pend_pkg::DEF_EDGE_MASK,
  parameter logic [NBITS-1:0] SW_MASK    = irq_pend_pkg::DEF_SW_MASK,
  parameter logic [NBITS-1:0] NMI_MASK   = irq_pend_pkg::DEF_NMI_MASK,
  parameter logic [NBITS*LVL_W-1:0] BIT_LVL = irq_pend_pkg::DEF_BIT_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] irq_lines,
  input  logic             sw_set_en,
  input  logic [NBITS-1:0] sw_set_data,
  input  logic             sw_clr_en,
  input  logic [NBITS-1:0] sw_clr_data,
  input  logic             en_wr,
  input  logic [NBITS-1:0] en_data,
  input  logic             nmi_taken,
  input  logic             wait_req,
  input  logic [LVL_W-1:0] wait_level,
  output logic [NBITS-1:0] pending,
  output logic [NBITS-1:0] enabled_pending,
  output logic [LVL_W-1:0] int_level,
  output logic             halted
);
  logic [NBITS-1:0] synced, rise, pend_nxt, pend_q;
  logic [NBITS-1:0] en_q, en_nxt, enp_q;
  logic [NBITS-1:0] above_cur, above_wait;
  logic [LVL_W-1:0] lvl_q;
  logic             halt_q;

  irq_line_sync #(.NBITS(NBITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .lines(irq_lines), .synced(synced), .rise(rise)
  );

  irq_pend_store #(
    .NBITS(NBITS), .LEVEL_MASK(LEVEL_MASK), .EDGE_MASK(EDGE_MASK),
    .SW_MASK(SW_MASK), .NMI_MASK(NMI_MASK)
  ) u_store (
    .clk(clk), .rst(rst), .synced(synced), .rise(rise),
    .set_en(sw_set_en), .set_data(sw_set_data),
    .clr_en(sw_clr_en), .clr_data(sw_clr_data),
    .nmi_taken(nmi_taken), .pend_nxt(pend_nxt), .pend_q(pend_q)
  );

  irq_above_mask #(.NBITS(NBITS), .LVL_W(LVL_W), .BIT_LVL(BIT_LVL),
                   .NMI_MASK(NMI_MASK)) u_above_cur (
    .thr(lvl_q), .above(above_cur)
  );

  irq_above_mask #(.NBITS(NBITS), .LVL_W(LVL_W), .BIT_LVL(BIT_LVL),
                   .NMI_MASK(NMI_MASK)) u_above_wait (
    .thr(wait_level), .above(above_wait)
  );

  assign en_nxt = en_wr ? en_data : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      enp_q  <= '0;
      lvl_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      enp_q <= pend_nxt & (en_nxt | NMI_MASK);
      if (wait_req) begin
        lvl_q  <= wait_level;
        halt_q <= ~|(enp_q & above_wait);
      end else if (halt_q && |(enp_q & above_cur)) begin
        halt_q <= 1'b0;
      end
    end
  end

  assign pending         = pend_q;
  assign enabled_pending = enp_q;
  assign int_level       = lvl_q;
  assign halted          = halt_q;
endmodule

// File: rtl/irq_pend_unit_chk.sv
module irq_pend_unit_chk #(
  parameter int unsigned NBITS = 32,
  parameter int unsigned LVL_W = 4,
  parameter logic [NBITS-1:0] SW_MASK  = '0,
  parameter logic [NBITS-1:0] NMI_MASK = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_set_en,
  input logic [NBITS-1:0] sw_set_data,
  input logic             nmi_taken,
  input logic             wait_req,
  input logic [LVL_W-1:0] wait_level,
  input logic [NBITS-1:0] pending,
  input logic [NBITS-1:0] enabled_pending,
  input logic [LVL_W-1:0] int_level,
  input logic             halted,
  input logic [NBITS-1:0] rise,
  input logic [NBITS-1:0] en_q,
  input logic [NBITS-1:0] above_cur,
  input logic [NBITS-1:0] above_wait
);
  p_sw_origin_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(pending) & SW_MASK &
               ~($past(sw_set_en) ? $past(sw_set_data) : '0)) == '0));

  p_nmi_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (nmi_taken && ((rise & NMI_MASK) == '0)) |=> ((pending & NMI_MASK) == '0));

  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    enabled_pending == (pending & (en_q | NMI_MASK)));

  p_wait_level_r9: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> (int_level == $past(wait_level)));

  p_wait_go_r9: assert property (@(posedge clk) disable iff (rst)
    (wait_req && |(enabled_pending & above_wait)) |=> !halted);

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (halted && !wait_req && |(enabled_pending & above_cur)) |=> !halted);
endmodule

bind irq_pend_unit irq_pend_unit_chk #(
  .NBITS(NBITS), .LVL_W(LVL_W), .SW_MASK(SW_MASK), .NMI_MASK(NMI_MASK)
) u_chk (.*);

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;
  localparam int N = 32;
  localparam logic [N-1:0] LVLM = 32'h0000_00FF;
  localparam logic [N-1:0] SWM  = 32'h7FFF_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] irq_lines = '0, sw_set_data = '0, sw_clr_data = '0, en_data = '0;
  logic sw_set_en = 0, sw_clr_en = 0, en_wr = 0, nmi_taken = 0, wait_req = 0;
  logic [3:0] wait_level = '0;
  logic [N-1:0] pending, enabled_pending;
  logic [3:0] int_level;
  logic halted;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_pend_unit uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines),
    .sw_set_en(sw_set_en), .sw_set_data(sw_set_data),
    .sw_clr_en(sw_clr_en), .sw_clr_data(sw_clr_data),
    .en_wr(en_wr), .en_data(en_data), .nmi_taken(nmi_taken),
    .wait_req(wait_req), .wait_level(wait_level),
    .pending(pending), .enabled_pending(enabled_pending),
    .int_level(int_level), .halted(halted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic sw_set(input logic [N-1:0] d);
    sw_set_en = 1; sw_set_data = d; tick(); sw_set_en = 0;
  endtask

  task automatic sw_clr(input logic [N-1:0] d);
    sw_clr_en = 1; sw_clr_data = d; tick(); sw_clr_en = 0;
  endtask

  task automatic write_en(input logic [N-1:0] d);
    en_wr = 1; en_data = d; tick(); en_wr = 0;
  endtask

  task automatic do_wait(input logic [3:0] l);
    wait_req = 1; wait_level = l; tick(); wait_req = 0;
  endtask

  task automatic t_reset;
    chk("R1 pending", pending, 0);
    chk("R1 enabled_pending", enabled_pending, 0);
    chk("R1 int_level", int_level, 0);
    chk("R1 halted", halted, 0);
  endtask

  task automatic t_sw;
    write_en('1);
    sw_set('1);
    chk("R2 set reaches software bits only", pending, SWM);
    chk("R8 enabled follows pending", enabled_pending, SWM);
    sw_clr('1);
    chk("R3 clear removes software bits", pending, 0);
  endtask

  task automatic t_edge;
    irq_lines = 32'h8000_0100;
    tick(2);
    chk("R4 not yet visible after 2 edges", pending, 0);
    tick();
    chk("R4 edge and nmi set after 3 edges", pending, 32'h8000_0100);
    irq_lines = '0;
    tick(3);
    chk("R4 stays set after line falls", pending, 32'h8000_0100);
    sw_set(32'h8000_0100);
    chk("R2 set has no effect on edge/nmi", pending, 32'h8000_0100);
    sw_clr('1);
    chk("R3 clear hits edge bit, not nmi", pending, 32'h8000_0000);
    nmi_taken = 1; tick(); nmi_taken = 0;
    chk("R7 nmi taken clears nmi bits", pending, 0);
  endtask

  task automatic t_level;
    irq_lines = 32'h0000_0001;
    tick(2);
    chk("R5 level latency 2", pending, 0);
    tick();
    chk("R5 level follows line high", pending, 32'h1);
    sw_clr(32'h1);
    chk("R3 clear ignores level bit", pending, 32'h1);
    sw_set(32'h2);
    chk("R2 set ignores level bit", pending, 32'h1);
    irq_lines = '0;
    tick(3);
    chk("R5 level follows line low", pending & LVLM, 0);
  endtask

  task automatic t_race;
    irq_lines = 32'h0000_0200;
    tick(2);
    sw_clr(32'h0000_0200);
    chk("R6 rise beats clear", pending, 32'h0000_0200);
    sw_clr(32'h0000_0200);
    chk("R3 later clear removes edge bit", pending, 0);
    irq_lines = '0;
    sw_set_en = 1; sw_set_data = 32'h0010_0000;
    sw_clr_en = 1; sw_clr_data = 32'h0010_0000;
    tick();
    sw_set_en = 0; sw_clr_en = 0;
    chk("R6 set beats clear", pending, 32'h0010_0000);
    sw_clr('1);
    tick(2);
  endtask

  task automatic t_mask;
    write_en('0);
    sw_set(32'h0001_0000);
    chk("R8 disabled bit gated", enabled_pending, 0);
    chk("R8 pending still set", pending, 32'h0001_0000);
    irq_lines = 32'h8000_0000;
    tick(3);
    chk("R8 nmi passes without enable", enabled_pending, 32'h8000_0000);
    irq_lines = '0;
    nmi_taken = 1; tick(); nmi_taken = 0;
    sw_clr('1);
    chk("R7 cleared for next test", pending, 0);
  endtask

  task automatic t_wait;
    write_en('1);
    sw_set(32'h0004_0000);           // bit 18, level 3
    do_wait(4'd2);
    chk("R9 level loaded", int_level, 2);
    chk("R9 pending above level: no halt", halted, 0);
    do_wait(4'd3);
    chk("R9 nothing above level: halt", halted, 1);
    sw_set(32'h0008_0000);           // bit 19, level 4
    chk("R10 not released on arrival edge", halted, 1);
    tick();
    chk("R10 released one edge later", halted, 0);
    sw_clr('1);
    write_en('0);
    sw_set(32'h0008_0000);
    do_wait(4'd0);
    chk("R9 disabled request leaves core halted", halted, 1);
    tick(2);
    chk("R10 disabled request keeps halt", halted, 1);
    irq_lines = 32'h8000_0000;
    tick(3);
    chk("R10 nmi arrival, halt holds one edge", halted, 1);
    tick();
    chk("R10 nmi releases halt", halted, 0);
  endtask

  initial begin
    tick(3);
    rst = 0;
    t_reset();
    t_sw();
    t_edge();
    t_level();
    t_race();
    t_mask();
    t_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule